// File: doc/BRIEF.md
# Successive-Approximation Converter Controller with Byte-Wide Readout

This block is the digital half of a 12-bit successive-approximation converter. A host starts a conversion with its parallel strobes. The block then walks a trial code from the most significant bit down to the least, driving an external DAC. At each falling edge of a slow conversion clock it keeps or drops one trial bit, based on a one-bit comparator answer. The analog comparator, the DAC and the oscillator sit outside the block.

When the thirteenth conversion-clock falling edge after the start arrives, the finished code goes into an output register and the busy flag clears. The host reads the 12-bit result as two bytes over an 8-bit bus, using a byte-select pin. An optional bipolar coding flips the result's top bit.

All host strobes and the conversion clock pass through synchronisers into the fast system clock domain. The start condition is edge-detected, so one long strobe yields one conversion.

Top module: `sar_byte_adc_ctrl`

## Requirements
- R1: After reset `busy_n` is 1, `dac_code` is 0, and the output register is 0. The bus is undriven (`dout_en`=0, `dout`=0).
- R2: A conversion starts only when `cs_n`, `rd_n` and `hben` are all 0 together. Any other combination, including a read with `hben`=1, starts nothing.
- R3: `busy_n` goes to 0 once the start is seen and stays 0 until the conversion ends. A start request made while a conversion runs is ignored, and it does not cause a second conversion afterwards.
- R4: If `cs_n`, `rd_n` and `hben` are held at 0 for longer than a whole conversion, exactly one conversion takes place.
- R5: On the 13th falling edge of `conv_clk` after the start, the result is latched and `busy_n` returns to 1.
- R6: The first trial code is 0x800. Falling edges 1 to 12 decide bits 11 down to 0. A bit is kept when `cmp_hi`=1 (input at or above `dac_code`) and cleared otherwise, and the next lower bit is then tried. The final code equals the input level.
- R7: While a conversion runs, the bus shows the previous result.
- R8: With `hben`=0 the bus carries result bits 7..0. With `hben`=1, bus bits 3..0 carry result bits 11..8 and bus bits 7..4 are 0.
- R9: The bus is driven (`dout_en`=1) only while `cs_n` and `rd_n` are both 0. Otherwise `dout_en`=0 and `dout`=0.
- R10: With `bipolar`=1 at the latching edge, result bit 11 is inverted. With `bipolar`=0 the result is straight binary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| conv_clk | input | 1 | Conversion clock; its falling edges pace the approximation |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| hben | input | 1 | Byte select: 1 picks the high byte and blocks starts |
| bipolar | input | 1 | 1 inverts the result MSB at latching |
| cmp_hi | input | 1 | Comparator: 1 when the input is at or above `dac_code` |
| dac_code | output | 12 | Trial code driven to the DAC |
| busy_n | output | 1 | 0 while a conversion runs |
| dout | output | 8 | Data byte (three-state data, zero when undriven) |
| dout_en | output | 1 | Pad output enable for `dout` |

## Verification
A host read and the end of a conversion can meet. The bench reads the high byte and then the low byte while a conversion is in flight. It expects the old result on the bus, and it expects the low-byte read (itself a start request) to be dropped. After the result latches, it expects no second conversion to begin. A per-cycle reference model of the synchroniser delays, the trial code and the latched result judges every clock. The counts of `busy_n` falling edges prove that requests made during a conversion and over-long strobes each led to exactly one conversion.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_CONV = 1'b1
  } phase_e;
endpackage

// File: rtl/sar_sync.sv
// Multi-stage synchroniser for a vector of independent level signals.
module sar_sync #(
  parameter int            W       = 4,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] stg_d;
    if (g == 0) begin : g_first
      assign stg_d = din;
    end else begin : g_next
      assign stg_d = stg_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[g] <= RST_VAL;
      else        stg_q[g] <= stg_d;
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/sar_events.sv
// Edge detection of the synchronised start request and conversion clock.
module sar_events (
  input  logic clk,
  input  logic rst_n,
  input  logic req_s,
  input  logic ck_s,
  input  logic conv_active,
  output logic start,
  output logic tick
);
  logic req_q, req_d;
  logic ck_q, ck_d;

  always_comb begin
    req_d = req_s;
    ck_d  = ck_s;
    start = req_s & ~req_q & ~conv_active;
    tick  = ~ck_s & ck_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      ck_q  <= 1'b0;
    end else begin
      req_q <= req_d;
      ck_q  <= ck_d;
    end
  end
endmodule

// File: rtl/sar_engine.sv
// Successive-approximation sequencer and result register.
module sar_engine
  import sar_ctrl_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tick,
  input  logic             cmp_hi,
  input  logic             bipolar,
  output phase_e           phase,
  output logic [WIDTH-1:0] trial,
  output logic [WIDTH-1:0] result
);
  localparam int CNT_W = $clog2(WIDTH + 2);
  localparam logic [CNT_W-1:0] LAST_DEC = CNT_W'(WIDTH);
  localparam logic [WIDTH-1:0] MSB_ONE  = {1'b1, {(WIDTH-1){1'b0}}};

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [WIDTH-1:0] trial_q, trial_d;
  logic [WIDTH-1:0] res_q, res_d;
  logic             state_en;

  always_comb begin
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    trial_d  = trial_q;
    res_d    = res_q;
    state_en = start | (tick & (phase_q == PH_CONV));
    if (start) begin
      phase_d = PH_CONV;
      cnt_d   = '0;
      trial_d = MSB_ONE;
    end else if (phase_q == PH_CONV && tick) begin
      if (cnt_q < LAST_DEC) begin
        // decide the bit under trial, then raise the next lower one
        for (int b = 0; b < WIDTH; b++) begin
          if (b + int'(cnt_q) == WIDTH - 1) trial_d[b] = cmp_hi;
          if (b + int'(cnt_q) == WIDTH - 2) trial_d[b] = 1'b1;
        end
        cnt_d = cnt_q + 1'b1;
      end else begin
        res_d   = bipolar ? (trial_q ^ MSB_ONE) : trial_q;
        phase_d = PH_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      trial_q <= '0;
      res_q   <= '0;
    end else if (state_en) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      trial_q <= trial_d;
      res_q   <= res_d;
    end
  end

  assign phase  = phase_q;
  assign trial  = trial_q;
  assign result = res_q;
endmodule

// File: rtl/sar_byte_mux.sv
// Byte selection and bus enable; WIDTH must lie between BUS_W+1 and 2*BUS_W.
module sar_byte_mux #(
  parameter int WIDTH = 12,
  parameter int BUS_W = 8
) (
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             hben,
  input  logic [WIDTH-1:0] result,
  output logic [BUS_W-1:0] dout,
  output logic             dout_en
);
  localparam int HI_BITS = WIDTH - BUS_W;

  logic [BUS_W-1:0] lo_byte, hi_byte;
  logic             drive;

  always_comb begin
    lo_byte = result[BUS_W-1:0];
    hi_byte = {{(BUS_W-HI_BITS){1'b0}}, result[WIDTH-1:BUS_W]};
    drive   = ~cs_n & ~rd_n;
    dout_en = drive;
    if (!drive)    dout = '0;
    else if (hben) dout = hi_byte;
    else           dout = lo_byte;
  end
endmodule

// File: rtl/sar_byte_adc_ctrl.sv
module sar_byte_adc_ctrl
  import sar_ctrl_pkg::*;
#(
  parameter int WIDTH       = 12,
  parameter int BUS_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_clk,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             hben,
  input  logic             bipolar,
  input  logic             cmp_hi,
  output logic [WIDTH-1:0] dac_code,
  output logic             busy_n,
  output logic [BUS_W-1:0] dout,
  output logic             dout_en
);
  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  // synchronised pins: {conv_clk, hben, rd_n, cs_n}
  logic [3:0] pins_s;
  logic       req_s;

  sar_sync #(
    .W      (4),
    .STAGES (SYNC_STAGES),
    .RST_VAL(4'b0111)
  ) i_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .din  ({conv_clk, hben, rd_n, cs_n}),
    .dout (pins_s)
  );

  assign req_s = ~pins_s[0] & ~pins_s[1] & ~pins_s[2];

  phase_e           phase;
  logic             conv_start;
  logic             conv_tick;
  logic [WIDTH-1:0] result_q;

  sar_events i_events (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req_s      (req_s),
    .ck_s       (pins_s[3]),
    .conv_active(phase == PH_CONV),
    .start      (conv_start),
    .tick       (conv_tick)
  );

  sar_engine #(.WIDTH(WIDTH)) i_engine (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .start  (conv_start),
    .tick   (conv_tick),
    .cmp_hi (cmp_hi),
    .bipolar(bipolar),
    .phase  (phase),
    .trial  (dac_code),
    .result (result_q)
  );

  sar_byte_mux #(.WIDTH(WIDTH), .BUS_W(BUS_W)) i_mux (
    .cs_n   (cs_n),
    .rd_n   (rd_n),
    .hben   (hben),
    .result (result_q),
    .dout   (dout),
    .dout_en(dout_en)
  );

  assign busy_n = (phase == PH_IDLE);
endmodule

// File: rtl/sar_ctrl_checker.sv
module sar_ctrl_checker #(
  parameter int WIDTH = 12,
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy_n,
  input logic             tick,
  input logic             hben,
  input logic             dout_en,
  input logic [BUS_W-1:0] dout,
  input logic [WIDTH-1:0] dac_code,
  input logic [WIDTH-1:0] result
);
  localparam int CW = $clog2(WIDTH + 3);
  localparam int HI_BITS = WIDTH - BUS_W;
  localparam logic [WIDTH-1:0] MSB_ONE = {1'b1, {(WIDTH-1){1'b0}}};

  logic [CW-1:0] ticks_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ticks_seen <= '0;
    else if (busy_n) ticks_seen <= '0;
    else if (tick)   ticks_seen <= ticks_seen + 1'b1;
  end

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_n && $past(!busy_n)) |-> $stable(result)); // R7

  AST_FIRST_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n) |-> (dac_code == MSB_ONE)); // R6

  AST_THIRTEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n) |-> (ticks_seen == CW'(WIDTH + 1))); // R5

  AST_HIGH_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_en && hben) |-> (dout[BUS_W-1:HI_BITS] == '0)); // R8
endmodule

bind sar_byte_adc_ctrl sar_ctrl_checker #(.WIDTH(WIDTH), .BUS_W(BUS_W)) i_chk (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .busy_n  (busy_n),
  .tick    (conv_tick),
  .hben    (hben),
  .dout_en (dout_en),
  .dout    (dout),
  .dac_code(dac_code),
  .result  (result_q)
);

// File: tb/test_sar_byte_adc_ctrl.sv
`timescale 1ns/1ps
module test_sar_byte_adc_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_clk = 1'b0;
  logic        cs_n = 1'b1, rd_n = 1'b1, hben = 1'b0, bipolar = 1'b0;
  logic        cmp_hi;
  logic [11:0] dac_code;
  logic        busy_n;
  logic [7:0]  dout;
  logic        dout_en;
  int          vin = 0;
  int          errs = 0, checks = 0, cyc = 0, falls = 0;
  bit          chk_on = 1'b0;
  bit          prev_busy = 1'b1;

  always #2.5 clk = ~clk;

  assign cmp_hi = (vin >= int'(dac_code));

  sar_byte_adc_ctrl i_sar_byte_adc_ctrl (
    .clk(clk), .rst_n(rst_n), .conv_clk(conv_clk), .cs_n(cs_n), .rd_n(rd_n),
    .hben(hben), .bipolar(bipolar), .cmp_hi(cmp_hi), .dac_code(dac_code),
    .busy_n(busy_n), .dout(dout), .dout_en(dout_en)
  );

  // conversion clock: 8 system clocks per period
  initial forever begin
    repeat (4) @(posedge clk);
    #1 conv_clk = ~conv_clk;
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  // ---------------- reference model (behavioural, per clock) ----------------
  bit        h1, h2, h3, c1, c2, c3, r1, r2, m_act;
  int        m_cnt;
  bit [11:0] m_trial, m_res;

  task automatic model_clear();
    h1 = 0; h2 = 0; h3 = 0; c1 = 0; c2 = 0; c3 = 0;
    m_act = 0; m_cnt = 0; m_trial = '0; m_res = '0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1 = 0; r2 = 0; model_clear();
    end else begin
      if (!r2) model_clear();
      else begin
        bit req_now, ok_start, ok_tick;
        req_now  = !cs_n && !rd_n && !hben;
        ok_start = h2 && !h3 && !m_act;
        ok_tick  = !c2 && c3;
        if (ok_start) begin
          m_act = 1; m_cnt = 0; m_trial = 12'h800;
        end else if (m_act && ok_tick) begin
          if (m_cnt < 12) begin
            m_trial[11-m_cnt] = (vin >= int'(m_trial));
            if (m_cnt < 11) m_trial[10-m_cnt] = 1'b1;
            m_cnt++;
          end else begin
            m_res = bipolar ? (m_trial ^ 12'h800) : m_trial;
            m_act = 0;
          end
        end
        h3 = h2; h2 = h1; h1 = req_now;
        c3 = c2; c2 = c1; c1 = conv_clk;
      end
      r2 = r1; r1 = 1;
    end
  end

  // per-cycle comparison and busy-fall counting
  always @(negedge clk) begin
    if (prev_busy && !busy_n) falls++;
    prev_busy = busy_n;
    if (chk_on) begin
      bit       e_en;
      bit [7:0] e_d;
      e_en = !cs_n && !rd_n;
      e_d  = !e_en ? 8'h00 : (hben ? {4'h0, m_res[11:8]} : m_res[7:0]);
      chk(busy_n == !m_act, "R3 R5 busy_n vs model", int'(busy_n), int'(!m_act));
      chk(dac_code == m_trial, "R6 trial code vs model", int'(dac_code), int'(m_trial));
      chk(dout_en == e_en, "R9 bus enable vs model", int'(dout_en), int'(e_en));
      chk(dout == e_d, "R8 R7 bus byte vs model", int'(dout), int'(e_d));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      errs++; checks++;
      $display("FAIL watchdog expired: actual=%0d expected<=60000", cyc);
      summary();
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pins(bit c, bit r, bit h);
    cs_n = c; rd_n = r; hben = h;
  endtask

  task automatic wait_idle();
    step(8);
    while (!busy_n) step(1);
    step(4);
  endtask

  task automatic read_byte(bit hb, output int val);
    pins(1'b0, 1'b0, hb);
    @(negedge clk);
    val = int'(dout);
    step(3);
    pins(1'b1, 1'b1, hb);
    step(2);
    hben = 1'b0;
    step(2);
  endtask

  task automatic start_conv(int v, bit bp);
    vin = v; bipolar = bp;
    step(1);
    pins(1'b0, 1'b0, 1'b0);
    step(3);
    pins(1'b1, 1'b1, 1'b0);
  endtask

  // full conversion, high read, then low read (which itself restarts)
  task automatic convert(int v, bit bp, output int hi, output int lo);
    start_conv(v, bp);
    wait_idle();
    read_byte(1'b1, hi);
    read_byte(1'b0, lo);
    wait_idle();
  endtask

  initial begin
    int hi, lo, f0;
    step(5);
    @(negedge clk);
    chk(busy_n == 1'b1, "R1 busy_n in reset", int'(busy_n), 1);
    chk(dout_en == 1'b0, "R1 bus enable in reset", int'(dout_en), 0);
    chk(dac_code == 12'h000, "R1 trial code in reset", int'(dac_code), 0);
    step(1);
    rst_n = 1'b1;
    step(5);
    chk_on = 1'b1;
    read_byte(1'b1, hi);
    chk(hi == 0, "R1 result zero after reset", hi, 0);

    // main conversion, unipolar
    start_conv(12'hA5C, 1'b0);
    step(6);
    chk(busy_n == 1'b0, "R3 busy_n low after start", int'(busy_n), 0);
    wait_idle();
    read_byte(1'b1, hi);
    read_byte(1'b0, lo);
    chk(hi == 8'h0A, "R8 high byte packed", hi, 8'h0A);
    chk(lo == 8'h5C, "R6 low byte of result", lo, 8'h5C);
    wait_idle();

    // R7 and R3: reads while a new conversion runs
    f0 = falls;
    start_conv(12'h3C1, 1'b0);
    step(12);
    chk(busy_n == 1'b0, "R3 still converting", int'(busy_n), 0);
    read_byte(1'b1, hi);
    chk(hi == 8'h0A, "R7 old high byte while busy", hi, 8'h0A);
    read_byte(1'b0, lo);
    chk(lo == 8'h5C, "R7 old low byte while busy", lo, 8'h5C);
    wait_idle();
    step(40);
    chk(falls == f0 + 1, "R3 start during conversion ignored", falls - f0, 1);
    read_byte(1'b1, hi);
    chk(hi == 8'h03, "R5 new high byte after end", hi, 8'h03);
    read_byte(1'b0, lo);
    chk(lo == 8'hC1, "R6 new low byte after end", lo, 8'hC1);
    wait_idle();

    // R2: partial strobe combinations start nothing
    f0 = falls;
    pins(1'b0, 1'b0, 1'b1); step(40);
    pins(1'b1, 1'b1, 1'b1); step(4); hben = 1'b0;
    pins(1'b1, 1'b0, 1'b0); step(20);
    @(negedge clk);
    chk(dout_en == 1'b0 && dout == 8'h00, "R9 bus quiet without select", int'(dout), 0);
    pins(1'b0, 1'b1, 1'b0); step(20);
    @(negedge clk);
    chk(dout_en == 1'b0, "R9 bus quiet without read", int'(dout_en), 0);
    pins(1'b1, 1'b1, 1'b0); step(20);
    chk(falls == f0, "R2 no start without all three low", falls - f0, 0);

    // R4: strobe held across a whole conversion
    f0 = falls;
    vin = 12'h7FF;
    step(1);
    pins(1'b0, 1'b0, 1'b0); step(400);
    pins(1'b1, 1'b1, 1'b0); step(30);
    chk(falls == f0 + 1, "R4 one conversion per held strobe", falls - f0, 1);
    read_byte(1'b1, hi);
    chk(hi == 8'h07, "R4 held strobe result", hi, 8'h07);

    // R10: bipolar coding
    convert(12'h123, 1'b1, hi, lo);
    chk(hi == 8'h09, "R10 bipolar MSB inverted", hi, 8'h09);
    chk(lo == 8'h23, "R10 bipolar low byte", lo, 8'h23);

    // R6: extremes
    convert(0, 1'b0, hi, lo);
    chk(hi == 0 && lo == 0, "R6 zero input", (hi << 8) | lo, 0);
    convert(4095, 1'b0, hi, lo);
    chk(hi == 8'h0F, "R6 full-scale high byte", hi, 8'h0F);
    chk(lo == 8'hFF, "R6 full-scale low byte", lo, 8'hFF);

    step(5);
    summary();
    $finish;
  end
endmodule